// File: doc/BRIEF.md
# Buck Skip-Mode Pulse Controller

This block is the digital pulse controller for one synchronous step-down converter. It decides whether the high-side switch runs at fixed frequency (PWM) or in a light-load pulse-skipping mode. It also decides when each high-side pulse starts and ends. The block runs on the fast system clock. A one-cycle `swTick` strobe marks the rising edge of the switching clock and the boundary between switching cycles.

All analog decisions arrive as comparator flags:
- inductor current crossing zero;
- switch current at about 20% of the peak limit;
- peak current limit;
- the PWM error-amplifier trip;
- three output-voltage comparisons: above 101.5%, at or below nominal, and below 98.5%.

When the mode bit allows automatic operation, the controller enters skip mode after a run of switching cycles that each contained a zero crossing. In skip mode, clock-synchronised pulses are each cut at the 20% current level. Pulsing pauses while the output sits above the upper threshold and resumes at nominal. Full PWM returns when the output sags below the lower threshold.

Top module: `buck_skip_pulse_ctrl`

## Requirements
- R1: A switching cycle runs from one `swTick` to the next, and a zero crossing seen during the tick cycle counts toward the cycle that this tick closes. With `autoMode`=1, the mode moves from PWM (`modeStatus`=2'b00) to skip-run (2'b01) at the clock edge of the tick that closes the ENTRY_CYCLES-th consecutive cycle with a zero crossing (default 16), and not earlier.
- R2: A switching cycle that closes without any zero crossing resets the consecutive-cycle count to zero, so a further ENTRY_CYCLES cycles with zero crossings are then needed.
- R3: In PWM and in skip-run, a `swTick` latches a pulse request, and `hsOn` is high in the following clock cycle unless a turn-off condition is present.
- R4: In skip-run, `iLowHit` ends the pulse in the same clock cycle and `pwmTrip` has no effect. In PWM, `pwmTrip` ends the pulse and `iLowHit` has no effect.
- R5: In skip-run, `vAbove` drops `hsOn` in the same clock cycle and moves the mode to skip-hold (2'b10) at the next edge. In skip-hold, no pulse starts and `hsOn` stays low.
- R6: From skip-hold, `vAtNom` returns the mode to skip-run at the next edge. From either skip state, `vBelow` returns the mode to PWM at the next edge with the count cleared.
- R7: With `autoMode`=0, the mode stays PWM and the count is held at zero. Clearing `autoMode` while in a skip state returns the mode to PWM at the next edge.
- R8: In every mode, `iPeakHit` drives `hsOn` low in the same clock cycle and ends the pulse.
- R9: With `enable`=0, `hsOn` is low, no pulse starts, the mode returns to PWM at the next edge and the count is held at zero.
- R10: While `rstN` is low, `modeStatus` is PWM (2'b00) and `hsOn` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Converter enable |
| autoMode | input | 1 | 1: automatic skip/PWM, 0: forced PWM |
| swTick | input | 1 | One-cycle strobe at each switching-clock rising edge |
| zeroCross | input | 1 | Inductor current crossed zero |
| pwmTrip | input | 1 | PWM current-sense comparator trip (pulse end in PWM) |
| iLowHit | input | 1 | Switch current reached about 20% of peak limit |
| iPeakHit | input | 1 | Switch current reached the peak limit |
| vAbove | input | 1 | Output above 101.5% of nominal |
| vAtNom | input | 1 | Output at or below nominal |
| vBelow | input | 1 | Output below 98.5% of nominal |
| hsOn | output | 1 | High-side switch request |
| modeStatus | output | 2 | 00 PWM, 01 skip-run, 10 skip-hold |

## Verification
The bench builds the block with the default ENTRY_CYCLES of 16 and a switching period of four system clocks. This makes the exact entry boundary reachable with a short run: a streak of 15 cycles must not enter skip, while 16 must. The same streak length is rebuilt after a broken streak, after forced PWM, after an undervoltage exit and after clearing the mode bit. This shows that each of these paths clears the count. Each skip-mode exit and pulse-termination path is driven cycle by cycle against the flag ordering stated in the requirements.

// File: rtl/buck_skip_pkg.sv
package buck_skip_pkg;

  typedef enum logic [1:0] {
    MODE_PWM       = 2'b00,
    MODE_SKIP_RUN  = 2'b01,
    MODE_SKIP_HOLD = 2'b10
  } skipMode_e;

  typedef struct packed {
    logic cntClear;    // hold streak count and cycle flag at zero
    logic pulseStart;  // latch a new high-side pulse request
    logic pulseKill;   // end the current pulse now
  } pulseStrobe_t;

endpackage

// File: rtl/buck_skip_datapath.sv
module buck_skip_datapath
  import buck_skip_pkg::*;
#(
  parameter int ENTRY_CYCLES = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         swTick,
  input  logic         zeroCross,
  input  pulseStrobe_t strobe,
  output logic         streakDone,
  output logic         hsLatch
);

  localparam int CNT_W = $clog2(ENTRY_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(ENTRY_CYCLES);

  logic [CNT_W-1:0] streakCnt;
  logic [CNT_W-1:0] streakNext;
  logic             zcSeen;
  logic             cycleHadZc;

  assign cycleHadZc = zcSeen | zeroCross;

  always_comb begin
    if (!cycleHadZc)
      streakNext = '0;
    else if (streakCnt == CNT_MAX)
      streakNext = CNT_MAX;
    else
      streakNext = streakCnt + 1'b1;
  end

  assign streakDone = swTick & cycleHadZc & (streakNext == CNT_MAX);

  always_ff @(posedge clk) begin
    if (!rstN || strobe.cntClear) begin
      streakCnt <= '0;
      zcSeen    <= 1'b0;
    end else if (swTick) begin
      streakCnt <= streakNext;
      zcSeen    <= 1'b0;
    end else if (zeroCross) begin
      zcSeen    <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      hsLatch <= 1'b0;
    else if (strobe.pulseStart)
      hsLatch <= 1'b1;
    else if (strobe.pulseKill)
      hsLatch <= 1'b0;
  end

endmodule

// File: rtl/buck_skip_control.sv
module buck_skip_control
  import buck_skip_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         enable,
  input  logic         autoMode,
  input  logic         swTick,
  input  logic         streakDone,
  input  logic         pwmTrip,
  input  logic         iLowHit,
  input  logic         iPeakHit,
  input  logic         vAbove,
  input  logic         vAtNom,
  input  logic         vBelow,
  output skipMode_e    modeState,
  output pulseStrobe_t strobe
);

  skipMode_e modeNext;

  always_comb begin
    modeNext = modeState;
    if (!enable) begin
      modeNext = MODE_PWM;
    end else begin
      case (modeState)
        MODE_PWM:
          if (autoMode && swTick && streakDone) modeNext = MODE_SKIP_RUN;
        MODE_SKIP_RUN:
          if (!autoMode || vBelow) modeNext = MODE_PWM;
          else if (vAbove)         modeNext = MODE_SKIP_HOLD;
        MODE_SKIP_HOLD:
          if (!autoMode || vBelow) modeNext = MODE_PWM;
          else if (vAtNom)         modeNext = MODE_SKIP_RUN;
        default:
          modeNext = MODE_PWM;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) modeState <= MODE_PWM;
    else       modeState <= modeNext;
  end

  always_comb begin
    strobe.cntClear   = !enable || !autoMode || (modeState != MODE_PWM);
    strobe.pulseStart = enable && swTick &&
                        ((modeState == MODE_PWM) ||
                         ((modeState == MODE_SKIP_RUN) && !vAbove));
    strobe.pulseKill  = !enable || iPeakHit ||
                        ((modeState == MODE_PWM) && pwmTrip) ||
                        ((modeState == MODE_SKIP_RUN) && (iLowHit || vAbove)) ||
                        (modeState == MODE_SKIP_HOLD);
  end

endmodule

// File: rtl/buck_skip_pulse_ctrl.sv
module buck_skip_pulse_ctrl
  import buck_skip_pkg::*;
#(
  parameter int ENTRY_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       autoMode,
  input  logic       swTick,
  input  logic       zeroCross,
  input  logic       pwmTrip,
  input  logic       iLowHit,
  input  logic       iPeakHit,
  input  logic       vAbove,
  input  logic       vAtNom,
  input  logic       vBelow,
  output logic       hsOn,
  output logic [1:0] modeStatus
);

  pulseStrobe_t strobe;
  skipMode_e    modeState;
  logic         streakDone;
  logic         hsLatch;

  buck_skip_control u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .enable     (enable),
    .autoMode   (autoMode),
    .swTick     (swTick),
    .streakDone (streakDone),
    .pwmTrip    (pwmTrip),
    .iLowHit    (iLowHit),
    .iPeakHit   (iPeakHit),
    .vAbove     (vAbove),
    .vAtNom     (vAtNom),
    .vBelow     (vBelow),
    .modeState  (modeState),
    .strobe     (strobe)
  );

  buck_skip_datapath #(.ENTRY_CYCLES(ENTRY_CYCLES)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .swTick     (swTick),
    .zeroCross  (zeroCross),
    .strobe     (strobe),
    .streakDone (streakDone),
    .hsLatch    (hsLatch)
  );

  assign hsOn       = hsLatch & ~strobe.pulseKill;
  assign modeStatus = modeState;

endmodule

// File: rtl/buck_skip_pulse_ctrl_chk.sv
module buck_skip_pulse_ctrl_chk (
  input logic       clk,
  input logic       rstN,
  input logic       enable,
  input logic       autoMode,
  input logic       swTick,
  input logic       iPeakHit,
  input logic       vAbove,
  input logic       vBelow,
  input logic       hsOn,
  input logic [1:0] modeStatus
);

  // R8: peak limit forces the switch off in the same cycle
  p_peak_off_r8: assert property (@(posedge clk) disable iff (!rstN)
    iPeakHit |-> !hsOn);

  // R5: no switch activity while holding above the upper threshold
  p_hold_quiet_r5: assert property (@(posedge clk) disable iff (!rstN)
    (modeStatus == 2'b10) |-> !hsOn);

  // R5: over-voltage in skip-run leads to skip-hold
  p_hold_entry_r5: assert property (@(posedge clk) disable iff (!rstN)
    ((modeStatus == 2'b01) && vAbove && !vBelow && autoMode && enable)
      |=> (modeStatus == 2'b10));

  // R6: under-voltage in any skip state returns to PWM
  p_below_exit_r6: assert property (@(posedge clk) disable iff (!rstN)
    ((modeStatus != 2'b00) && vBelow) |=> (modeStatus == 2'b00));

  // R7: forced PWM keeps or returns the mode to PWM
  p_forced_pwm_r7: assert property (@(posedge clk) disable iff (!rstN)
    !autoMode |=> (modeStatus == 2'b00));

  // R9: disabled converter returns to PWM
  p_disable_pwm_r9: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (modeStatus == 2'b00));

  // R1: skip entry only at a switching tick with automatic mode allowed
  p_entry_tick_r1: assert property (@(posedge clk) disable iff (!rstN)
    ((modeStatus == 2'b01) && ($past(modeStatus) == 2'b00))
      |-> ($past(swTick) && $past(autoMode) && $past(enable)));

endmodule

bind buck_skip_pulse_ctrl buck_skip_pulse_ctrl_chk u_chk (.*);

// File: tb/buck_skip_pulse_ctrl_tb.sv
module buck_skip_pulse_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] M_PWM  = 2'b00;
  localparam logic [1:0] M_RUN  = 2'b01;
  localparam logic [1:0] M_HOLD = 2'b10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0, autoMode = 1'b0, swTick = 1'b0, zeroCross = 1'b0;
  logic pwmTrip = 1'b0, iLowHit = 1'b0, iPeakHit = 1'b0;
  logic vAbove = 1'b0, vAtNom = 1'b0, vBelow = 1'b0;
  logic hsOn;
  logic [1:0] modeStatus;

  logic cfgEn = 1'b1, cfgAm = 1'b1;
  int nChecks = 0, nFail = 0;
  bit finished = 0;

  typedef struct {
    logic [1:0] mode;
    logic       hs;
    string      tag;
  } expItem_t;
  expItem_t sbQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  buck_skip_pulse_ctrl u_dut (
    .clk(clk), .rstN(rstN), .enable(enable), .autoMode(autoMode),
    .swTick(swTick), .zeroCross(zeroCross), .pwmTrip(pwmTrip),
    .iLowHit(iLowHit), .iPeakHit(iPeakHit), .vAbove(vAbove),
    .vAtNom(vAtNom), .vBelow(vBelow), .hsOn(hsOn), .modeStatus(modeStatus)
  );

  // Driver: one clock cycle of stimulus plus the expected outputs for it
  task automatic drive(input logic tk, zc, trip, ilow, ipk, vab, vnom, vbl,
                       input logic en, am, input logic [1:0] expMode,
                       input logic expHs, input string tag);
    expItem_t it;
    @(posedge clk); #1;
    swTick = tk; zeroCross = zc; pwmTrip = trip; iLowHit = ilow;
    iPeakHit = ipk; vAbove = vab; vAtNom = vnom; vBelow = vbl;
    enable = en; autoMode = am;
    it.mode = expMode; it.hs = expHs; it.tag = tag;
    sbQ.push_back(it);
  endtask

  // Monitor: compares mid-cycle, away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      if (sbQ.size() > 0) begin
        expItem_t it;
        it = sbQ.pop_front();
        nChecks++;
        if (modeStatus !== it.mode || hsOn !== it.hs) begin
          nFail++;
          $display("FAIL %s: mode=%b hsOn=%b expected mode=%b hsOn=%b",
                   it.tag, modeStatus, hsOn, it.mode, it.hs);
        end
      end
    end
  end

  // PWM switching period: tick, pulse, trip ends it
  task automatic pwmPeriod(input logic zc, input logic pk, input string tag);
    drive(1,0,0,0,0,0,0,0, cfgEn,cfgAm, M_PWM, 1'b0, tag);
    drive(0,0,0,0,pk,0,0,0, cfgEn,cfgAm, M_PWM, !pk, tag);
    drive(0,zc,1,0,0,0,0,0, cfgEn,cfgAm, M_PWM, 1'b0, tag);
    drive(0,0,0,0,0,0,0,0, cfgEn,cfgAm, M_PWM, 1'b0, tag);
  endtask

  // Period whose tick closes the 16th zero-crossing cycle
  task automatic entryPeriod(input string tag);
    drive(1,0,0,0,0,0,0,0, cfgEn,cfgAm, M_PWM, 1'b0, tag);
    drive(0,0,0,0,0,0,0,0, cfgEn,cfgAm, M_RUN, 1'b1, tag);
    drive(0,0,1,1,0,0,0,0, cfgEn,cfgAm, M_RUN, 1'b0, tag);
    drive(0,0,0,0,0,0,0,0, cfgEn,cfgAm, M_RUN, 1'b0, tag);
  endtask

  // Skip pulse: PWM trip ignored, 20% flag ends it
  task automatic skipPeriod(input string tag);
    drive(1,0,0,0,0,0,0,0, cfgEn,cfgAm, M_RUN, 1'b0, tag);
    drive(0,0,0,0,0,0,0,0, cfgEn,cfgAm, M_RUN, 1'b1, tag);
    drive(0,0,1,0,0,0,0,0, cfgEn,cfgAm, M_RUN, 1'b1, {tag, " R4 trip ignored"});
    drive(0,0,0,1,0,0,0,0, cfgEn,cfgAm, M_RUN, 1'b0, {tag, " R4 20pct end"});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    nChecks++;
    if (modeStatus !== M_PWM || hsOn !== 1'b0) begin
      nFail++;
      $display("FAIL R10 reset: mode=%b hsOn=%b expected mode=00 hsOn=0",
               modeStatus, hsOn);
    end
    @(posedge clk); #1;
    rstN = 1'b1; enable = 1'b1; autoMode = 1'b1;

    // R8 in PWM, then R1/R2 streak handling
    pwmPeriod(1, 1, "R8 peak in PWM");
    for (int i = 0; i < 14; i++) pwmPeriod(1, 0, "R1 R3 streak");
    pwmPeriod(0, 0, "R2 gap cycle");
    for (int i = 0; i < 15; i++) pwmPeriod(1, 0, "R2 rebuild");
    pwmPeriod(0, 0, "R2 no entry after 15");

    // R7 forced PWM blocks entry
    cfgAm = 1'b0;
    for (int i = 0; i < 17; i++) pwmPeriod(1, 0, "R7 forced PWM");
    cfgAm = 1'b1;
    for (int i = 0; i < 16; i++) pwmPeriod(1, 0, "R1 fresh streak");
    entryPeriod("R1 entry at 16");

    skipPeriod("R3 skip pulse");
    skipPeriod("R3 skip pulse 2");

    // R8 peak in skip
    drive(1,0,0,0,0,0,0,0, 1,1, M_RUN, 1'b0, "R8 skip tick");
    drive(0,0,0,0,1,0,0,0, 1,1, M_RUN, 1'b0, "R8 peak in skip");
    drive(0,0,0,0,0,0,0,0, 1,1, M_RUN, 1'b0, "R8 pulse ended");
    drive(0,0,0,0,0,0,0,0, 1,1, M_RUN, 1'b0, "R8 idle");

    // R5 over-voltage then hold
    drive(1,0,0,0,0,0,0,0, 1,1, M_RUN,  1'b0, "R5 tick");
    drive(0,0,0,0,0,0,0,0, 1,1, M_RUN,  1'b1, "R5 pulse on");
    drive(0,0,0,0,0,1,0,0, 1,1, M_RUN,  1'b0, "R5 off at once");
    drive(0,0,0,0,0,1,0,0, 1,1, M_HOLD, 1'b0, "R5 hold entered");
    drive(1,0,0,0,0,0,0,0, 1,1, M_HOLD, 1'b0, "R5 hold tick");
    drive(0,0,0,0,0,0,0,0, 1,1, M_HOLD, 1'b0, "R5 no pulse in hold");
    drive(0,0,0,0,0,0,1,0, 1,1, M_HOLD, 1'b0, "R6 at nominal");
    drive(0,0,0,0,0,0,0,0, 1,1, M_RUN,  1'b0, "R6 back to skip-run");
    skipPeriod("R6 pulsing resumed");

    // R7 mode bit cleared in skip
    drive(1,0,0,0,0,0,0,0, 1,1, M_RUN, 1'b0, "R7 tick");
    drive(0,0,0,0,0,0,0,0, 1,1, M_RUN, 1'b1, "R7 pulse on");
    drive(0,0,0,0,0,0,0,0, 1,0, M_RUN, 1'b1, "R7 bit cleared");
    drive(0,0,0,0,0,0,0,0, 1,0, M_PWM, 1'b1, "R7 PWM next edge");
    drive(0,0,1,0,0,0,0,0, 1,0, M_PWM, 1'b0, "R7 PWM trip ends");
    for (int i = 0; i < 16; i++) pwmPeriod(1, 0, "R7 recount");
    entryPeriod("R7 re-entry at 16");

    // R6 under-voltage exit, count restarts
    drive(1,0,0,0,0,0,0,0, 1,1, M_RUN, 1'b0, "R6 tick");
    drive(0,0,0,0,0,0,0,0, 1,1, M_RUN, 1'b1, "R6 pulse");
    drive(0,0,0,1,0,0,0,0, 1,1, M_RUN, 1'b0, "R6 pulse end");
    drive(0,0,0,0,0,0,0,1, 1,1, M_RUN, 1'b0, "R6 below seen");
    drive(1,0,0,0,0,0,0,0, 1,1, M_PWM, 1'b0, "R6 back to PWM");
    drive(0,0,0,0,0,0,0,0, 1,1, M_PWM, 1'b1, "R6 PWM pulse");
    drive(0,1,0,1,0,0,0,0, 1,1, M_PWM, 1'b1, "R4 20pct ignored in PWM");
    drive(0,0,1,0,0,0,0,0, 1,1, M_PWM, 1'b0, "R4 trip ends PWM");
    for (int i = 0; i < 15; i++) pwmPeriod(1, 0, "R6 count restarted");
    entryPeriod("R6 entry after 16 new");

    // R9 disable
    drive(1,0,0,0,0,0,0,0, 1,1, M_RUN, 1'b0, "R9 tick");
    drive(0,0,0,0,0,0,0,0, 1,1, M_RUN, 1'b1, "R9 pulse");
    drive(0,0,0,0,0,0,0,0, 0,1, M_RUN, 1'b0, "R9 off when disabled");
    drive(0,0,0,0,0,0,0,0, 0,1, M_PWM, 1'b0, "R9 PWM when disabled");
    drive(1,0,0,0,0,0,0,0, 0,1, M_PWM, 1'b0, "R9 tick disabled");
    drive(0,0,0,0,0,0,0,0, 0,1, M_PWM, 1'b0, "R9 no pulse disabled");
    pwmPeriod(0, 0, "R9 re-enabled");

    repeat (2) @(negedge clk);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

endmodule